// File: doc/BRIEF.md
# I/O Port Decoder with Flags

This block sits on the I/O side of a small processor bus. While an I/O instruction executes, the processor places a 3-bit device code on dedicated code lines. At all other times those lines rest at zero. The memory read strobe doubles as the transfer direction. From the code and the strobe, the block raises a combinational input-select line for the device that must drive the data bus. For an output transfer, it captures the bus byte into that device's output latch when timing pulse B falls, and it pulses a one-cycle strobe for that device.

The block also holds a single-bit serial output flag, which two dedicated opcodes set and clear. It also reports ready status for two parallel ports on two external flag lines. A secondary port-select register, written through one reserved output code, chooses which of the two ports is reported. Every input is sampled on one system clock, and timing pulse B is edge-detected against that clock.

Top module: `io_port_decoder`

## Requirements
- R1: Reset (rst_n low) clears the serial flag, every output latch, every output strobe and the port select. After reset, port select 0 (port A) is active.
- R2: Device code 0 selects nothing. With code 0, in_sel and out_stb stay all zero and no latch changes, whatever the read strobe, the bus data and timing pulse B do.
- R3: in_sel bit k-1 is high in the same cycle exactly when io_code equals k (1..7) and rd_strobe is high. Otherwise it is low.
- R4: A falling edge of tpb is a cycle with tpb low after a cycle with tpb high. On that edge, with io_code = k (nonzero) and rd_strobe low, bus_data is loaded into latch k. The new value appears at out_data bits [(k-1)*8 +: 8] from the next clock edge, and all other latches keep their values.
- R5: Each capture raises out_stb bit k-1 for exactly one cycle, aligned with the new latch value. Only one strobe bit is ever high.
- R6: A falling edge of tpb while rd_strobe is high changes no latch and raises no strobe.
- R7: When op_valid is high, opcode 0x7B sets q_out and opcode 0x7A clears it, effective from the next edge. Any other opcode, or op_valid low, leaves q_out unchanged.
- R8: An output capture on code 7 also loads bit 0 of bus_data into the port select: 0 selects port A and 1 selects port B. Latch 7 stores the full byte as usual.
- R9: flag_a equals ready_a while port A is selected and is 0 otherwise. flag_b equals ready_b while port B is selected and is 0 otherwise. Both follow their inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_code | input | 3 | Device code, zero outside I/O execution |
| rd_strobe | input | 1 | Memory read strobe, high = device to memory |
| tpb | input | 1 | Timing pulse B |
| bus_data | input | 8 | Data bus value from the processor |
| op_valid | input | 1 | Opcode qualifier |
| opcode | input | 8 | Current instruction opcode |
| ready_a | input | 1 | Ready status of parallel port A |
| ready_b | input | 1 | Ready status of parallel port B |
| in_sel | output | 7 | Input-select per device, bit k-1 for code k |
| out_stb | output | 7 | One-cycle capture strobe per device |
| out_data | output | 56 | Output latches, device k at bits (k-1)*8 +: 8 |
| q_out | output | 1 | Serial output flag |
| flag_a | output | 1 | Qualified ready of port A |
| flag_b | output | 1 | Qualified ready of port B |

## Verification
The bench uses the default parameters: seven devices, an 8-bit bus, and port select on code 7. With these values, every device code, the top code doubling as the select write, and code 0 can all be reached in a short run. One vector table sweeps inputs and outputs across devices, including an overwrite of a latch and a read-direction pulse that must not capture. Directed cases then cover the opcode pair and foreign opcodes, both port-select settings, and a reset in the middle of a run.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
    localparam logic [7:0] OP_Q_SET = 8'h7B;
    localparam logic [7:0] OP_Q_CLR = 8'h7A;

    typedef enum logic {
        PORT_A = 1'b0,
        PORT_B = 1'b1
    } port_sel_e;
endpackage

// File: rtl/io_code_decoder.sv
module io_code_decoder #(
    parameter int NUM_DEV = 7,
    localparam int CODE_W = $clog2(NUM_DEV + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  code,
    input  logic               rd,
    output logic [NUM_DEV-1:0] in_sel,
    output logic [NUM_DEV-1:0] wr_hit
);
    for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
        logic match;
        assign match     = (code == CODE_W'(k + 1));
        assign in_sel[k] = match & rd;
        assign wr_hit[k] = match & ~rd;
    end

    assert_in_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_sel));
    assert_in_sel_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_sel) |-> rd);
    assert_code_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '0) |-> (in_sel == '0 && wr_hit == '0));
endmodule

// File: rtl/io_out_latch_bank.sv
module io_out_latch_bank #(
    parameter int NUM_DEV = 7,
    parameter int DATA_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tpb,
    input  logic [NUM_DEV-1:0]        wr_hit,
    input  logic [DATA_W-1:0]         data,
    output logic                      fall_evt,
    output logic [NUM_DEV-1:0]        out_stb,
    output logic [NUM_DEV*DATA_W-1:0] out_data
);
    typedef struct packed {
        logic                           tpb;
        logic [NUM_DEV-1:0]             stb;
        logic [NUM_DEV-1:0][DATA_W-1:0] dat;
    } bank_st_t;

    bank_st_t st_d, st_q;

    assign fall_evt = st_q.tpb & ~tpb;

    always_comb begin
        st_d     = st_q;
        st_d.tpb = tpb;
        st_d.stb = '0;
        if (fall_evt) begin
            for (int k = 0; k < NUM_DEV; k++) begin
                if (wr_hit[k]) begin
                    st_d.stb[k] = 1'b1;
                    st_d.dat[k] = data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_stb  = st_q.stb;
    assign out_data = st_q.dat;

    assert_stb_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_stb));
    assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_stb) |=> ((out_stb & $past(out_stb)) == '0));
    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb == '0) |-> $stable(out_data));
endmodule

// File: rtl/io_flag_ctrl.sv
module io_flag_ctrl
    import io_dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [7:0] opcode,
    input  logic       sel_wr,
    input  logic       sel_bit,
    input  logic       ready_a,
    input  logic       ready_b,
    output logic       q_out,
    output logic       flag_a,
    output logic       flag_b
);
    typedef struct packed {
        logic      q;
        port_sel_e sel;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (op_valid && opcode == OP_Q_SET) st_d.q = 1'b1;
        if (op_valid && opcode == OP_Q_CLR) st_d.q = 1'b0;
        if (sel_wr) st_d.sel = port_sel_e'(sel_bit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{q: 1'b0, sel: PORT_A};
        else        st_q <= st_d;
    end

    assign q_out  = st_q.q;
    assign flag_a = ready_a & (st_q.sel == PORT_A);
    assign flag_b = ready_b & (st_q.sel == PORT_B);

    assert_q_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_Q_SET) |=> q_out);
    assert_q_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_Q_CLR) |=> !q_out);
    assert_q_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && (opcode == OP_Q_SET || opcode == OP_Q_CLR)) |=> $stable(q_out));
    assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_a && flag_b));
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder #(
    parameter int NUM_DEV  = 7,
    parameter int DATA_W   = 8,
    parameter int SEL_CODE = 7,
    localparam int CODE_W  = $clog2(NUM_DEV + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CODE_W-1:0]         io_code,
    input  logic                      rd_strobe,
    input  logic                      tpb,
    input  logic [DATA_W-1:0]         bus_data,
    input  logic                      op_valid,
    input  logic [7:0]                opcode,
    input  logic                      ready_a,
    input  logic                      ready_b,
    output logic [NUM_DEV-1:0]        in_sel,
    output logic [NUM_DEV-1:0]        out_stb,
    output logic [NUM_DEV*DATA_W-1:0] out_data,
    output logic                      q_out,
    output logic                      flag_a,
    output logic                      flag_b
);
    logic [NUM_DEV-1:0] wr_hit;
    logic               fall_evt;

    io_code_decoder #(.NUM_DEV(NUM_DEV)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .code   (io_code),
        .rd     (rd_strobe),
        .in_sel (in_sel),
        .wr_hit (wr_hit)
    );

    io_out_latch_bank #(.NUM_DEV(NUM_DEV), .DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .tpb      (tpb),
        .wr_hit   (wr_hit),
        .data     (bus_data),
        .fall_evt (fall_evt),
        .out_stb  (out_stb),
        .out_data (out_data)
    );

    io_flag_ctrl u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .opcode   (opcode),
        .sel_wr   (fall_evt & wr_hit[SEL_CODE-1]),
        .sel_bit  (bus_data[0]),
        .ready_a  (ready_a),
        .ready_b  (ready_b),
        .q_out    (q_out),
        .flag_a   (flag_a),
        .flag_b   (flag_b)
    );

    assert_read_no_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_evt && rd_strobe) |=> (out_stb == '0));
endmodule

// File: tb/io_port_decoder_tb.sv
module io_port_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NDEV = 7;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  io_code = 0;
    logic        rd_strobe = 0;
    logic        tpb = 0;
    logic [7:0]  bus_data = 0;
    logic        op_valid = 0;
    logic [7:0]  opcode = 0;
    logic        ready_a = 0;
    logic        ready_b = 0;
    logic [6:0]  in_sel;
    logic [6:0]  out_stb;
    logic [55:0] out_data;
    logic        q_out, flag_a, flag_b;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] exp_lat [NDEV];

    always #(CLK_PERIOD/2) clk = ~clk;

    io_port_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .io_code(io_code), .rd_strobe(rd_strobe),
        .tpb(tpb), .bus_data(bus_data), .op_valid(op_valid), .opcode(opcode),
        .ready_a(ready_a), .ready_b(ready_b), .in_sel(in_sel), .out_stb(out_stb),
        .out_data(out_data), .q_out(q_out), .flag_a(flag_a), .flag_b(flag_b)
    );

    // {rd, code[2:0], data[7:0]}
    localparam logic [11:0] VEC [8] = '{
        {1'b0, 3'd1, 8'hA5},
        {1'b0, 3'd2, 8'h3C},
        {1'b0, 3'd7, 8'h00},
        {1'b0, 3'd3, 8'hFF},
        {1'b1, 3'd4, 8'h77},
        {1'b0, 3'd4, 8'h81},
        {1'b0, 3'd1, 8'h5A},
        {1'b0, 3'd0, 8'hEE}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    task automatic check_latches(input string tag);
        for (int k = 0; k < NDEV; k++)
            chk(out_data[k*8 +: 8] == exp_lat[k], tag, out_data[k*8 +: 8], exp_lat[k]);
    endtask

    task automatic bus_cycle(input logic rd, input logic [2:0] code, input logic [7:0] d);
        logic [6:0] exp_sel;
        logic [6:0] exp_stb;
        exp_sel = (rd && code != 0) ? 7'(1 << (code - 1)) : 7'd0;
        exp_stb = (!rd && code != 0) ? 7'(1 << (code - 1)) : 7'd0;
        @(negedge clk);
        io_code = code; rd_strobe = rd; bus_data = d; tpb = 1;
        #1;
        chk(in_sel == exp_sel, "R3 in_sel", in_sel, exp_sel);
        @(negedge clk);
        tpb = 0;
        @(negedge clk);
        chk(out_stb == exp_stb, "R5/R6/R2 strobe", out_stb, exp_stb);
        if (!rd && code != 0) exp_lat[code-1] = d;
        check_latches("R4/R6/R2 latch");
        io_code = 0; rd_strobe = 0;
        @(negedge clk);
        chk(out_stb == 7'd0, "R5 strobe one cycle", out_stb, 0);
    endtask

    task automatic op(input logic v, input logic [7:0] o, input logic exp_q, input string tag);
        @(negedge clk);
        op_valid = v; opcode = o;
        @(negedge clk);
        op_valid = 0; opcode = 0;
        chk(q_out == exp_q, tag, q_out, exp_q);
    endtask

    initial begin
        for (int k = 0; k < NDEV; k++) exp_lat[k] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(q_out == 0, "R1 q reset", q_out, 0);
        chk(out_data == 0, "R1 latches reset", out_data, 0);
        chk(out_stb == 0, "R1 strobes reset", out_stb, 0);
        rst_n = 1;
        ready_a = 1; ready_b = 1;
        #1;
        chk(flag_a == 1 && flag_b == 0, "R1/R9 select A after reset", {flag_a, flag_b}, 2'b10);

        for (int i = 0; i < 8; i++)
            bus_cycle(VEC[i][11], VEC[i][10:8], VEC[i][7:0]);

        // R2: code 0 read direction selects nothing
        bus_cycle(1'b1, 3'd0, 8'h11);
        // R6: read on device 2 must not overwrite latch 2
        bus_cycle(1'b1, 3'd2, 8'h99);

        // R8/R9: switch to port B
        bus_cycle(1'b0, 3'd7, 8'h03);
        ready_a = 1; ready_b = 1; #1;
        chk(flag_a == 0 && flag_b == 1, "R8/R9 select B", {flag_a, flag_b}, 2'b01);
        ready_b = 0; #1;
        chk(flag_b == 0, "R9 flag_b follows ready_b", flag_b, 0);
        bus_cycle(1'b0, 3'd7, 8'hFE);
        ready_a = 1; ready_b = 1; #1;
        chk(flag_a == 1 && flag_b == 0, "R8/R9 back to A", {flag_a, flag_b}, 2'b10);
        ready_a = 0; #1;
        chk(flag_a == 0, "R9 flag_a follows ready_a", flag_a, 0);

        // R2: tpb fall with code 0 and write direction, held high without fall
        @(negedge clk); io_code = 0; rd_strobe = 0; bus_data = 8'h42; tpb = 1;
        repeat (3) @(negedge clk);
        chk(out_stb == 0, "R4 tpb high no capture", out_stb, 0);
        tpb = 0;
        repeat (2) @(negedge clk);
        check_latches("R2 code zero no capture");

        // R7 serial flag
        op(1'b1, 8'h7B, 1'b1, "R7 set");
        op(1'b1, 8'h00, 1'b1, "R7 other opcode keeps");
        op(1'b1, 8'h7A, 1'b0, "R7 clear");
        op(1'b0, 8'h7B, 1'b0, "R7 invalid ignored");
        op(1'b1, 8'h7C, 1'b0, "R7 near opcode ignored");
        op(1'b1, 8'h7B, 1'b1, "R7 set again");

        // switch to port B then reset mid-run
        bus_cycle(1'b0, 3'd7, 8'h01);
        @(negedge clk); rst_n = 0;
        #1;
        for (int k = 0; k < NDEV; k++) exp_lat[k] = 0;
        chk(q_out == 0, "R1 q mid reset", q_out, 0);
        check_latches("R1 latches mid reset");
        ready_a = 1; ready_b = 1; #1;
        chk(flag_a == 1 && flag_b == 0, "R1 select A mid reset", {flag_a, flag_b}, 2'b10);
        @(negedge clk); rst_n = 1;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule